// File: doc/BRIEF.md
# Ring Bus Member Node Interface

This block is the bus logic of one ordinary member node on a four-wire ring. Each node receives a data wire and a clock wire from the node before it, and it drives a data wire and a clock wire to the node after it. The node has no clock of its own. Every register is clocked by the incoming bus clock. Incoming bits are taken on the rising edge, and outgoing bits are changed on the falling edge. When the node is neither sending nor the addressed receiver, the data and clock go straight through it. A layer controller beside the node sees a transmit request and acknowledge port and a receive word port.

After reset the node is in standby. In standby it can ask the rest of the ring to wake up by pulling its data output low. The first four bus clock rising edges then release the node's local domains one step at a time, in this order: power gate, local clock, isolation, reset.

After that, each run of bus clock pulses forms a frame of 43 rising edges, numbered as slots 0 to 42:
- Slot 0 is in-line arbitration.
- Slot 1 is a priority override.
- Slots 2 to 9 carry an 8-bit address, most significant bit first.
- Slots 10 to 41 carry a 32-bit word, most significant bit first.
- Slot 42 is the acknowledge from the receiver.

Between frames the bus clock rests high.

Top module: `ring_node`

## Requirements
- R1: When the node is neither transmitting nor the addressed receiver, `dataOut` follows `dataIn` combinationally. `clkOut` always follows `busClkIn`.
- R2: While reset is asserted, all four release outputs are low and `txAck`, `txOk`, `rxValid` are low.
- R3: In standby, before any bus clock rising edge has been seen, `wakeReq` high forces `dataOut` low. After the first rising edge the wake request no longer pulls `dataOut` low.
- R4: The 1st, 2nd, 3rd and 4th rising edges after reset raise `pwrGateRel`, `clkRel`, `isoRel` and `rstRel`, in that order. Each output, once raised, stays high until reset.
- R5: Once awake, the node counts rising edges within a frame: slot 0 arbitration, slot 1 priority, slots 2 to 9 address, slots 10 to 41 data, slot 42 acknowledge. `dataIn` is taken at each rising edge. After slot 42 the node returns to slot 0.
- R6: An awake node that is idle at slot 0 with `txReq` high pulls `dataOut` low only while `busClkIn` is high.
- R7: At the slot 0 edge, a requesting node that sees `dataIn` high becomes the owner. One that sees `dataIn` low forwards the rest of the frame and raises no `txAck`. If `txReq` is still high, it requests again in the next frame.
- R8: A node with `txReq` and `txPri` high that does not own the bus after slot 0 drives `dataOut` low for slot 1. It becomes the owner if it sees `dataIn` high at the slot 1 edge. An owner that sees `dataIn` low at the slot 1 edge gives up the bus.
- R9: The owner drives `{txAddr, txData}` most significant bit first for slots 2 to 41. It changes `dataOut` only on falling edges of `busClkIn`.
- R10: At the slot 42 edge of a frame the node owned, `txAck` goes high until the next rising edge. `txOk` is high with it exactly when `dataIn` was low at that edge.
- R11: If the address taken in slots 2 to 9 equals `NODE_ADDR` (default 8'h5A) on a node that does not own the bus, the node does the following:
  - It drives `dataOut` high for slots 10 to 41.
  - It shifts the data bits into `rxData`, most significant bit first.
  - It drives `dataOut` low for slot 42.
  - It raises `rxValid` from the slot 42 edge until the next rising edge.
- R12: On a frame for another address, the node forwards every bit and `rxData` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClkIn | input | 1 | Bus clock from the previous node; clocks all node registers |
| rstN | input | 1 | Asynchronous active-low reset, returns node to standby |
| dataIn | input | 1 | Data from the previous node |
| dataOut | output | 1 | Data to the next node |
| clkOut | output | 1 | Bus clock to the next node |
| wakeReq | input | 1 | Asks the ring to wake while in standby |
| pwrGateRel | output | 1 | Releases the local power gate |
| clkRel | output | 1 | Releases the local clock |
| isoRel | output | 1 | Removes local isolation |
| rstRel | output | 1 | Releases local reset |
| txReq | input | 1 | Layer asks to send a frame |
| txPri | input | 1 | The request uses the priority slot |
| txAddr | input | 8 | Destination address of the frame to send |
| txData | input | 32 | Word to send |
| txAck | output | 1 | A frame this node owned has ended |
| txOk | output | 1 | The receiver acknowledged the frame |
| rxValid | output | 1 | A word addressed to this node has arrived |
| rxData | output | 32 | Received word |

## Verification
The case that combines two functions is a node that loses arbitration at slot 0 while it is also the destination of that same frame. In that one frame the pending transmit request must be dropped and reception must take over.

The bench provokes this case as follows. It holds `txReq` high, pulls the upstream data low at slot 0, and sends a frame carrying the node's own address.

The result is judged in three ways:
- The receive scoreboard must see the expected word.
- The node must drive the acknowledge low.
- No transmit acknowledge may appear.

// File: rtl/ringnode_pkg.sv
`timescale 1ns/1ps
package ringnode_pkg;
  localparam int SLOT_BITS  = 8;
  localparam int WAKE_STEPS = 4;

  typedef enum logic [1:0] {
    ROLE_FWD = 2'd0,
    ROLE_TX  = 2'd1,
    ROLE_RX  = 2'd2
  } role_e;

  typedef struct packed {
    logic                 awake;
    logic                 wakeFresh;
    logic [SLOT_BITS-1:0] slot;
    role_e                role;
    logic                 loadFrame;
    logic                 shiftAddr;
    logic                 shiftData;
    logic                 closeFrame;
  } node_strb_t;
endpackage

// File: rtl/ringnode_ctrl.sv
`timescale 1ns/1ps
module ringnode_ctrl
  import ringnode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  busClk,
  input  logic                  rstN,
  input  logic                  dataIn,
  input  logic                  txReq,
  input  logic                  txPri,
  input  logic                  addrHit,
  output node_strb_t            strb,
  output logic [WAKE_STEPS-1:0] relVec
);
  localparam int WAKE_W = $clog2(WAKE_STEPS + 1);
  localparam logic [SLOT_BITS-1:0] S_LAST_ADDR  = SLOT_BITS'(1 + ADDR_W);
  localparam logic [SLOT_BITS-1:0] S_FIRST_DATA = SLOT_BITS'(2 + ADDR_W);
  localparam logic [SLOT_BITS-1:0] S_LAST_BIT   = SLOT_BITS'(1 + ADDR_W + DATA_W);
  localparam logic [SLOT_BITS-1:0] S_ACK        = SLOT_BITS'(2 + ADDR_W + DATA_W);
  localparam logic [SLOT_BITS-1:0] S_ONE        = SLOT_BITS'(1);
  localparam logic [SLOT_BITS-1:0] S_TWO        = SLOT_BITS'(2);

  logic [WAKE_W-1:0]    wakeCnt;
  logic [SLOT_BITS-1:0] slot, slotNext;
  role_e                role, roleNext;
  logic                 awake;

  assign awake = (wakeCnt == WAKE_W'(WAKE_STEPS));

  // frame sequencing and ownership
  always_comb begin
    slotNext = slot;
    roleNext = role;
    if (awake) begin
      if (slot == S_ACK) begin
        slotNext = '0;
        roleNext = ROLE_FWD;
      end else begin
        slotNext = slot + S_ONE;
        if (slot == '0) begin
          roleNext = (txReq && dataIn) ? ROLE_TX : ROLE_FWD;
        end else if (slot == S_ONE) begin
          if (role == ROLE_TX && !dataIn)
            roleNext = ROLE_FWD;
          else if (role != ROLE_TX && txReq && txPri && dataIn)
            roleNext = ROLE_TX;
        end else if (slot == S_LAST_ADDR && role == ROLE_FWD && addrHit) begin
          roleNext = ROLE_RX;
        end
      end
    end
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
      slot    <= '0;
      role    <= ROLE_FWD;
    end else if (!awake) begin
      wakeCnt <= wakeCnt + WAKE_W'(1);
    end else begin
      slot <= slotNext;
      role <= roleNext;
    end
  end

  always_comb begin
    strb.awake      = awake;
    strb.wakeFresh  = (wakeCnt == '0);
    strb.slot       = slot;
    strb.role       = role;
    strb.loadFrame  = awake && (slot == S_ONE) && (roleNext == ROLE_TX);
    strb.shiftAddr  = awake && (slot >= S_TWO) && (slot <= S_LAST_ADDR) && (role != ROLE_TX);
    strb.shiftData  = awake && (slot >= S_FIRST_DATA) && (slot <= S_LAST_BIT) && (role == ROLE_RX);
    strb.closeFrame = awake && (slot == S_ACK);
  end

  // staged release of local domains
  for (genvar g = 0; g < WAKE_STEPS; g++) begin : g_rel
    assign relVec[g] = (wakeCnt > WAKE_W'(g));
    if (g > 0) begin : g_ord
      p_wake_order_r4: assert property (@(posedge busClk) disable iff (!rstN)
        $rose(relVec[g]) |-> $past(relVec[g-1]));
    end
  end

  p_slot_step_r5: assert property (@(posedge busClk) disable iff (!rstN)
    (awake && slot != '0 && slot != S_ACK) |=> (slot == $past(slot) + S_ONE));

  p_ack_wraps_r5: assert property (@(posedge busClk) disable iff (!rstN)
    (awake && slot == S_ACK) |=> (slot == '0 && role == ROLE_FWD));

  p_lost_arb_r7: assert property (@(posedge busClk) disable iff (!rstN)
    (awake && slot == '0 && txReq && !dataIn) |=> (role != ROLE_TX));
endmodule

// File: rtl/ringnode_dpath.sv
`timescale 1ns/1ps
module ringnode_dpath
  import ringnode_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] NODE_ADDR = 8'h5A
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              dataIn,
  input  logic              wakeReq,
  input  logic              txReq,
  input  logic              txPri,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [DATA_W-1:0] txData,
  input  node_strb_t        strb,
  output logic              addrHit,
  output logic              dataOut,
  output logic              txAck,
  output logic              txOk,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [SLOT_BITS-1:0] S_ONE        = SLOT_BITS'(1);
  localparam logic [SLOT_BITS-1:0] S_TWO        = SLOT_BITS'(2);
  localparam logic [SLOT_BITS-1:0] S_FIRST_DATA = SLOT_BITS'(2 + ADDR_W);
  localparam logic [SLOT_BITS-1:0] S_LAST_BIT   = SLOT_BITS'(1 + FRAME_W);
  localparam logic [SLOT_BITS-1:0] S_ACK        = SLOT_BITS'(2 + FRAME_W);

  logic [FRAME_W-1:0]   frameWord;
  logic [ADDR_W-1:0]    addrSh;
  logic [DATA_W-1:0]    rxSh;
  logic                 drvEn, drvVal;
  logic                 txAckQ, txOkQ, rxValidQ;
  logic [SLOT_BITS-1:0] bitIdx;
  logic                 txBit, inBits, inData, arbPull;

  assign addrHit = ({addrSh[ADDR_W-2:0], dataIn} == NODE_ADDR);
  assign bitIdx  = S_LAST_BIT - strb.slot;
  assign txBit   = frameWord[bitIdx[IDX_W-1:0]];
  assign inBits  = (strb.slot >= S_TWO) && (strb.slot <= S_LAST_BIT);
  assign inData  = (strb.slot >= S_FIRST_DATA) && (strb.slot <= S_LAST_BIT);
  assign arbPull = strb.awake && (strb.slot == '0) && txReq && busClk;

  // rising edge: capture
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      frameWord <= '0;
      addrSh    <= '0;
      rxSh      <= '0;
      txAckQ    <= 1'b0;
      txOkQ     <= 1'b0;
      rxValidQ  <= 1'b0;
    end else begin
      if (strb.loadFrame) frameWord <= {txAddr, txData};
      if (strb.shiftAddr) addrSh <= {addrSh[ADDR_W-2:0], dataIn};
      if (strb.shiftData) rxSh <= {rxSh[DATA_W-2:0], dataIn};
      txAckQ   <= strb.closeFrame && (strb.role == ROLE_TX);
      txOkQ    <= strb.closeFrame && (strb.role == ROLE_TX) && !dataIn;
      rxValidQ <= strb.closeFrame && (strb.role == ROLE_RX);
    end
  end

  // falling edge: launch
  always_ff @(negedge busClk or negedge rstN) begin
    if (!rstN) begin
      drvEn  <= 1'b0;
      drvVal <= 1'b1;
    end else begin
      drvEn  <= 1'b0;
      drvVal <= 1'b1;
      if (strb.awake) begin
        if (strb.slot == S_ONE && strb.role != ROLE_TX && txReq && txPri) begin
          drvEn  <= 1'b1;
          drvVal <= 1'b0;
        end else if (strb.role == ROLE_TX && inBits) begin
          drvEn  <= 1'b1;
          drvVal <= txBit;
        end else if (strb.role == ROLE_RX && inData) begin
          drvEn  <= 1'b1;
          drvVal <= 1'b1;
        end else if (strb.role == ROLE_RX && strb.slot == S_ACK) begin
          drvEn  <= 1'b1;
          drvVal <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (!strb.awake)
      dataOut = (wakeReq && strb.wakeFresh) ? 1'b0 : dataIn;
    else if (arbPull)
      dataOut = 1'b0;
    else if (drvEn && strb.slot != '0)
      dataOut = drvVal;
    else
      dataOut = dataIn;
  end

  assign txAck   = txAckQ;
  assign txOk    = txOkQ;
  assign rxValid = rxValidQ;
  assign rxData  = rxSh;

  p_rx_hold_r12: assert property (@(posedge busClk) disable iff (!rstN)
    (strb.awake && strb.role == ROLE_FWD) |=> $stable(rxSh));

  p_frame_hold_r9: assert property (@(posedge busClk) disable iff (!rstN)
    (strb.role == ROLE_TX && strb.slot >= S_TWO) |=> $stable(frameWord));

  p_ok_needs_ack_r10: assert property (@(posedge busClk) disable iff (!rstN)
    txOk |-> txAck);

  p_no_dual_done_r11: assert property (@(posedge busClk) disable iff (!rstN)
    !(txAck && rxValid));
endmodule

// File: rtl/ring_node.sv
`timescale 1ns/1ps
module ring_node
  import ringnode_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] NODE_ADDR = 8'h5A
) (
  input  logic              busClkIn,
  input  logic              rstN,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              clkOut,
  input  logic              wakeReq,
  output logic              pwrGateRel,
  output logic              clkRel,
  output logic              isoRel,
  output logic              rstRel,
  input  logic              txReq,
  input  logic              txPri,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [DATA_W-1:0] txData,
  output logic              txAck,
  output logic              txOk,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);
  node_strb_t            strb;
  logic [WAKE_STEPS-1:0] relVec;
  logic                  addrHit;

  ringnode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busClk (busClkIn),
    .rstN   (rstN),
    .dataIn (dataIn),
    .txReq  (txReq),
    .txPri  (txPri),
    .addrHit(addrHit),
    .strb   (strb),
    .relVec (relVec)
  );

  ringnode_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NODE_ADDR(NODE_ADDR)) u_dpath (
    .busClk (busClkIn),
    .rstN   (rstN),
    .dataIn (dataIn),
    .wakeReq(wakeReq),
    .txReq  (txReq),
    .txPri  (txPri),
    .txAddr (txAddr),
    .txData (txData),
    .strb   (strb),
    .addrHit(addrHit),
    .dataOut(dataOut),
    .txAck  (txAck),
    .txOk   (txOk),
    .rxValid(rxValid),
    .rxData (rxData)
  );

  assign clkOut     = busClkIn;
  assign pwrGateRel = relVec[0];
  assign clkRel     = relVec[1];
  assign isoRel     = relVec[2];
  assign rstRel     = relVec[3];
endmodule

// File: tb/ring_node_bench.sv
`timescale 1ns/1ps
module ring_node_bench;
  logic        busClkIn, rstN, dataIn, wakeReq, txReq, txPri;
  logic [7:0]  txAddr;
  logic [31:0] txData;
  logic        dataOut, clkOut, pwrGateRel, clkRel, isoRel, rstRel;
  logic        txAck, txOk, rxValid;
  logic [31:0] rxData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] rxExpQ[$];
  bit          txExpQ[$];

  ring_node u_ring_node (
    .busClkIn(busClkIn), .rstN(rstN), .dataIn(dataIn), .dataOut(dataOut),
    .clkOut(clkOut), .wakeReq(wakeReq), .pwrGateRel(pwrGateRel), .clkRel(clkRel),
    .isoRel(isoRel), .rstRel(rstRel), .txReq(txReq), .txPri(txPri),
    .txAddr(txAddr), .txData(txData), .txAck(txAck), .txOk(txOk),
    .rxValid(rxValid), .rxData(rxData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus clock period of 5 ns (200 MHz)
  task automatic wakeEdge();
    busClkIn = 1'b0; #2.5;
    busClkIn = 1'b1; #1;
  endtask

  task automatic runFrame(input bit arbIn, input bit priIn, input logic [39:0] upWord,
                          input bit ackIn, output logic [39:0] outWord,
                          output bit arbOut, output bit priOut, output bit outAck,
                          output bit stableOk);
    stableOk = 1'b1;
    outWord  = '0;
    arbOut   = 1'b0;
    priOut   = 1'b0;
    outAck   = 1'b0;
    for (int k = 0; k <= 42; k++) begin
      logic din, pre, post;
      if (k == 0) din = arbIn;
      else if (k == 1) din = priIn;
      else if (k <= 41) din = upWord[41-k];
      else din = ackIn;
      busClkIn = 1'b0;
      dataIn = din;
      #2;
      pre = dataOut;
      #0.5;
      busClkIn = 1'b1;
      #1;
      post = dataOut;
      #1.5;
      if (k == 0) arbOut = pre;
      if (k == 1) priOut = pre;
      if (k >= 2 && k <= 41) begin
        outWord[41-k] = pre;
        if (pre !== post) stableOk = 1'b0;
      end
      if (k == 42) outAck = pre;
    end
    dataIn = 1'b1;
    #2;
  endtask

  // scoreboard monitors
  initial begin
    forever begin
      @(posedge rxValid);
      #1;
      if (rxExpQ.size() == 0) check(1'b0, "R11 unexpected rxValid", 64'(rxData), 64'h0);
      else begin
        logic [31:0] e;
        e = rxExpQ.pop_front();
        check(rxData === e, "R11 received word", 64'(rxData), 64'(e));
      end
    end
  end

  initial begin
    forever begin
      @(posedge txAck);
      #1;
      if (txExpQ.size() == 0) check(1'b0, "R7 unexpected txAck", 64'(txOk), 64'h0);
      else begin
        bit e;
        e = txExpQ.pop_front();
        check(txOk === e, "R10 txOk result", 64'(txOk), 64'(e));
      end
    end
  end

  initial begin
    #100us;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [39:0] ow;
    bit ao, po, ak, st;
    busClkIn = 1'b1; rstN = 1'b0; dataIn = 1'b1; wakeReq = 1'b0;
    txReq = 1'b0; txPri = 1'b0; txAddr = '0; txData = '0;
    #3;
    // R2 reset state
    check({rstRel, isoRel, clkRel, pwrGateRel} === 4'b0000, "R2 releases in reset",
          64'({rstRel, isoRel, clkRel, pwrGateRel}), 64'h0);
    check({txAck, txOk, rxValid} === 3'b000, "R2 status in reset",
          64'({txAck, txOk, rxValid}), 64'h0);
    rstN = 1'b1; #2;
    // R1 forwarding in standby
    dataIn = 1'b0; #1;
    check(dataOut === 1'b0 && clkOut === 1'b1, "R1 forward low", 64'({dataOut, clkOut}), 64'h1);
    dataIn = 1'b1; #1;
    check(dataOut === 1'b1, "R1 forward high", 64'(dataOut), 64'h1);
    // R3 wake pull
    wakeReq = 1'b1; #1;
    check(dataOut === 1'b0, "R3 wake pull", 64'(dataOut), 64'h0);
    // R4 staged release
    wakeEdge();
    check({rstRel, isoRel, clkRel, pwrGateRel} === 4'b0001, "R4 step1",
          64'({rstRel, isoRel, clkRel, pwrGateRel}), 64'h1);
    check(dataOut === 1'b1, "R3 pull ends after first edge", 64'(dataOut), 64'h1);
    #1.5; wakeEdge();
    check({rstRel, isoRel, clkRel, pwrGateRel} === 4'b0011, "R4 step2",
          64'({rstRel, isoRel, clkRel, pwrGateRel}), 64'h3);
    #1.5; wakeEdge();
    check({rstRel, isoRel, clkRel, pwrGateRel} === 4'b0111, "R4 step3",
          64'({rstRel, isoRel, clkRel, pwrGateRel}), 64'h7);
    #1.5; wakeEdge();
    check({rstRel, isoRel, clkRel, pwrGateRel} === 4'b1111, "R4 step4",
          64'({rstRel, isoRel, clkRel, pwrGateRel}), 64'hf);
    #1.5; wakeReq = 1'b0; #1;

    // R12 frame for another address
    runFrame(1'b1, 1'b1, {8'h33, 32'hDEAD_BEEF}, 1'b1, ow, ao, po, ak, st);
    check(ow === {8'h33, 32'hDEAD_BEEF}, "R12 forwarded bits", 64'(ow), 64'({8'h33, 32'hDEAD_BEEF}));
    check(rxData === 32'h0, "R12 rxData kept", 64'(rxData), 64'h0);
    check({rstRel, isoRel, clkRel, pwrGateRel} === 4'b1111, "R4 releases stay",
          64'({rstRel, isoRel, clkRel, pwrGateRel}), 64'hf);

    // R11 / R5 receive
    rxExpQ.push_back(32'hA5C3_0F96);
    runFrame(1'b1, 1'b1, {8'h5A, 32'hA5C3_0F96}, 1'b1, ow, ao, po, ak, st);
    check(ow === {8'h5A, 32'hFFFF_FFFF}, "R11 receiver stops forwarding", 64'(ow),
          64'({8'h5A, 32'hFFFF_FFFF}));
    check(ak === 1'b0, "R11 ack driven low", 64'(ak), 64'h0);
    rxExpQ.push_back(32'h8000_0001);
    runFrame(1'b1, 1'b0, {8'h5A, 32'h8000_0001}, 1'b1, ow, ao, po, ak, st);
    check(ak === 1'b0, "R5 second receive ack", 64'(ak), 64'h0);

    // R6 / R9 / R10 transmit and win
    txAddr = 8'h21; txData = 32'h1234_5678; txReq = 1'b1; #1;
    check(dataOut === 1'b0, "R6 request pull with clock high", 64'(dataOut), 64'h0);
    txExpQ.push_back(1'b1);
    runFrame(1'b1, 1'b1, 40'hFF_FFFF_FFFF, 1'b0, ow, ao, po, ak, st);
    txReq = 1'b0;
    check(ao === 1'b1, "R6 no pull with clock low", 64'(ao), 64'h1);
    check(ow === {8'h21, 32'h1234_5678}, "R9 transmitted word", 64'(ow), 64'({8'h21, 32'h1234_5678}));
    check(st === 1'b1, "R9 changes on falling edge only", 64'(st), 64'h1);

    // R10 no acknowledge
    txData = 32'hFFFF_0000; txReq = 1'b1;
    txExpQ.push_back(1'b0);
    runFrame(1'b1, 1'b1, 40'hFF_FFFF_FFFF, 1'b1, ow, ao, po, ak, st);
    txReq = 1'b0;
    check(ow === {8'h21, 32'hFFFF_0000}, "R9 second word", 64'(ow), 64'({8'h21, 32'hFFFF_0000}));

    // R7 lose then retry
    txData = 32'h0F0F_3C3C; txReq = 1'b1;
    runFrame(1'b0, 1'b1, {8'h33, 32'h0BAD_F00D}, 1'b1, ow, ao, po, ak, st);
    check(ow === {8'h33, 32'h0BAD_F00D}, "R7 loser forwards", 64'(ow), 64'({8'h33, 32'h0BAD_F00D}));
    check(txAck === 1'b0, "R7 no ack after loss", 64'(txAck), 64'h0);
    txExpQ.push_back(1'b1);
    runFrame(1'b1, 1'b1, 40'hFF_FFFF_FFFF, 1'b0, ow, ao, po, ak, st);
    txReq = 1'b0;
    check(ow === {8'h21, 32'h0F0F_3C3C}, "R7 retry wins", 64'(ow), 64'({8'h21, 32'h0F0F_3C3C}));

    // R8 priority win after loss
    txData = 32'hC001_D00D; txReq = 1'b1; txPri = 1'b1;
    txExpQ.push_back(1'b1);
    runFrame(1'b0, 1'b1, 40'hFF_FFFF_FFFF, 1'b0, ow, ao, po, ak, st);
    txReq = 1'b0; txPri = 1'b0;
    check(po === 1'b0, "R8 priority pull", 64'(po), 64'h0);
    check(ow === {8'h21, 32'hC001_D00D}, "R8 priority owner sends", 64'(ow), 64'({8'h21, 32'hC001_D00D}));

    // R8 owner yields to upstream priority
    txReq = 1'b1;
    runFrame(1'b1, 1'b0, {8'h44, 32'h5555_AAAA}, 1'b1, ow, ao, po, ak, st);
    txReq = 1'b0;
    check(ow === {8'h44, 32'h5555_AAAA}, "R8 owner yields", 64'(ow), 64'({8'h44, 32'h5555_AAAA}));
    check(txAck === 1'b0, "R8 no ack after yield", 64'(txAck), 64'h0);

    // R7 + R11 lost arbitration while addressed
    txReq = 1'b1;
    rxExpQ.push_back(32'h600D_CAFE);
    runFrame(1'b0, 1'b1, {8'h5A, 32'h600D_CAFE}, 1'b1, ow, ao, po, ak, st);
    txReq = 1'b0;
    check(ow === {8'h5A, 32'hFFFF_FFFF}, "R11 loser becomes receiver", 64'(ow),
          64'({8'h5A, 32'hFFFF_FFFF}));
    check(ak === 1'b0, "R11 loser acks", 64'(ak), 64'h0);
    check(rxData === 32'h600D_CAFE, "R12 word kept after frame", 64'(rxData), 64'h600DCAFE);

    #10;
    check(rxExpQ.size() == 0, "R11 all words seen", 64'(rxExpQ.size()), 64'h0);
    check(txExpQ.size() == 0, "R10 all results seen", 64'(txExpQ.size()), 64'h0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule